// File: doc/BRIEF.md
# Load-Use Stall and Bubble Control

This block guards a five-stage in-order pipeline against the single read-after-write case that operand forwarding cannot repair: a load sitting in the execute stage whose destination register is read by the instruction directly behind it, still in decode. A loaded value only exists at the end of the memory stage. The dependent instruction, however, wants it at the start of its own execute stage, which falls in that same cycle. The block holds the dependent instruction back by one cycle.

When the case is detected, the block freezes the program counter and the fetch/decode pipeline register for one cycle. In the same cycle it replaces the decode-to-execute hand-off with a no-op bubble. To do that it clears the control bits that could change architectural state: register write, memory read and memory write. The data fields are left as they are, because no stage uses them once the controls are clear.

A one-bit history register records whether the previous cycle stalled. A stall therefore never lasts longer than one cycle: on the following cycle the bubble is the occupant of the execute stage. Instructions two or three slots behind a load are not stalled, because forwarding and the split-cycle register file already cover them.

Top module: `lu_stall_unit`

## Requirements
- R1: While rstN is low, pcWriteEn and ifIdWriteEn are 1, idExBubble is 0, and idExCtrlOut equals idExCtrlIn.
- R2: A stall happens when all of the following hold:
  - exValid, exIsLoad and idValid are 1;
  - exDestReg is nonzero;
  - idUse[0] is 1 and source A (idSrc bits 4:0) equals exDestReg.

  During the stall, in the same cycle, pcWriteEn is 0, ifIdWriteEn is 0 and idExBubble is 1.
- R3: Under the same conditions, source B (idSrc bits 9:5) equal to exDestReg with idUse[1] set causes a stall.
- R4: A source field that equals exDestReg while its use flag is 0 causes no stall.
- R5: A load whose exDestReg is register 0 never causes a stall.
- R6: An execute-stage instruction that is not a load (exIsLoad = 0) never causes a stall, even when its destination matches.
- R7: When exValid or idValid is 0, no stall is raised.
- R8: While idExBubble is 1, idExCtrlOut is all zero. idExCtrlOut bit 0 is register write, bit 1 is memory read and bit 2 is memory write. Otherwise idExCtrlOut equals idExCtrlIn.
- R9: A stall lasts exactly one cycle. In the cycle after a stall no stall is raised, whatever the inputs.
- R10: pcWriteEn and ifIdWriteEn are always equal, and idExBubble is always their inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| exValid | input | 1 | Execute-stage slot holds a real instruction |
| exIsLoad | input | 1 | Execute-stage instruction is a load |
| exDestReg | input | REG_W | Destination register of the execute-stage instruction |
| idValid | input | 1 | Decode-stage slot holds a real instruction |
| idSrc | input | NUM_SRC*REG_W | Decode-stage source fields; source i at bits i*REG_W +: REG_W |
| idUse | input | NUM_SRC | Per-source flag: source is actually read |
| idExCtrlIn | input | CTRL_W | Decoded controls heading into the execute stage |
| pcWriteEn | output | 1 | Program counter may update |
| ifIdWriteEn | output | 1 | Fetch/decode register may update |
| idExBubble | output | 1 | Decode-to-execute hand-off is a bubble this cycle |
| idExCtrlOut | output | CTRL_W | Controls passed on, cleared during a bubble |

## Verification
A wrong stall history bit shows up immediately at the ports. If it is stuck high, a genuine load-use pattern is not stalled. If it is stuck low, idExBubble stays high for two cycles when the same pattern is held. Either fault is visible in the very next cycle after a stall. A wrong comparator or a wrong gating term shows up in the same cycle as the inputs that trigger it, as a missing or spurious bubble. A fault in the clearing path shows up as a nonzero control field during a bubble. Because the outputs are combinational apart from the history bit, every fault becomes visible within one clock.

// File: rtl/lu_stall_pkg.sv
package lu_stall_pkg;

  // Strobes sent from the hazard control to the enable/bubble datapath.
  typedef struct packed {
    logic holdFront;     // freeze PC and fetch/decode register
    logic insertBubble;  // replace decode-to-execute content with a no-op
  } stallStrobes_t;

  // Control field positions inside the decode-to-execute control word.
  localparam int unsigned CTRL_REG_WRITE = 0;
  localparam int unsigned CTRL_MEM_READ  = 1;
  localparam int unsigned CTRL_MEM_WRITE = 2;

endpackage

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl
  import lu_stall_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     exValid,
  input  logic                     exIsLoad,
  input  logic [REG_W-1:0]         exDestReg,
  input  logic                     idValid,
  input  logic [NUM_SRC*REG_W-1:0] idSrc,
  input  logic [NUM_SRC-1:0]       idUse,
  output stallStrobes_t            strobes
);

  logic [NUM_SRC-1:0] srcHit;
  logic               loadLive;
  logic               hazard;
  logic               stallPrev;

  // One comparator per source operand.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_srcCmp
    assign srcHit[i] = idUse[i] && (idSrc[i*REG_W +: REG_W] == exDestReg);
  end

  // Register 0 is never a true dependence.
  assign loadLive = exValid && exIsLoad && (exDestReg != '0);

  // The history term caps the stall at one cycle.
  assign hazard = rstN && loadLive && idValid && (|srcHit) && !stallPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallPrev <= 1'b0;
    end else begin
      stallPrev <= hazard;
    end
  end

  always_comb begin
    strobes.holdFront    = hazard;
    strobes.insertBubble = hazard;
  end

endmodule

// File: rtl/lu_stall_dp.sv
module lu_stall_dp
  import lu_stall_pkg::*;
#(
  parameter int unsigned CTRL_W = 3
) (
  input  stallStrobes_t     strobes,
  input  logic [CTRL_W-1:0] ctrlIn,
  output logic              pcWriteEn,
  output logic              ifIdWriteEn,
  output logic              idExBubble,
  output logic [CTRL_W-1:0] ctrlOut
);

  assign pcWriteEn   = !strobes.holdFront;
  assign ifIdWriteEn = !strobes.holdFront;
  assign idExBubble  = strobes.insertBubble;

  // Clear every state-changing control bit when a bubble is inserted.
  for (genvar b = 0; b < CTRL_W; b++) begin : g_ctrlMask
    assign ctrlOut[b] = ctrlIn[b] && !strobes.insertBubble;
  end

endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit
  import lu_stall_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned CTRL_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     exValid,
  input  logic                     exIsLoad,
  input  logic [REG_W-1:0]         exDestReg,
  input  logic                     idValid,
  input  logic [NUM_SRC*REG_W-1:0] idSrc,
  input  logic [NUM_SRC-1:0]       idUse,
  input  logic [CTRL_W-1:0]        idExCtrlIn,
  output logic                     pcWriteEn,
  output logic                     ifIdWriteEn,
  output logic                     idExBubble,
  output logic [CTRL_W-1:0]        idExCtrlOut
);

  stallStrobes_t strobes;

  lu_stall_ctrl #(
    .REG_W  (REG_W),
    .NUM_SRC(NUM_SRC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .exValid  (exValid),
    .exIsLoad (exIsLoad),
    .exDestReg(exDestReg),
    .idValid  (idValid),
    .idSrc    (idSrc),
    .idUse    (idUse),
    .strobes  (strobes)
  );

  lu_stall_dp #(
    .CTRL_W(CTRL_W)
  ) u_dp (
    .strobes    (strobes),
    .ctrlIn     (idExCtrlIn),
    .pcWriteEn  (pcWriteEn),
    .ifIdWriteEn(ifIdWriteEn),
    .idExBubble (idExBubble),
    .ctrlOut    (idExCtrlOut)
  );

endmodule

// File: rtl/lu_stall_chk.sv
module lu_stall_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned CTRL_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              exValid,
  input logic              exIsLoad,
  input logic [REG_W-1:0]  exDestReg,
  input logic              idValid,
  input logic [CTRL_W-1:0] idExCtrlIn,
  input logic              pcWriteEn,
  input logic              ifIdWriteEn,
  input logic              idExBubble,
  input logic [CTRL_W-1:0] idExCtrlOut
);

  // R1
  reset_pass_chk: assert property (@(posedge clk)
    !rstN |-> (pcWriteEn && ifIdWriteEn && !idExBubble));

  // R5
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exDestReg == '0) |-> !idExBubble);

  // R6
  not_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !exIsLoad |-> !idExBubble);

  // R7
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(exValid && idValid) |-> !idExBubble);

  // R8
  bubble_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    idExBubble |-> (idExCtrlOut == '0));

  // R8
  ctrl_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idExBubble |-> (idExCtrlOut == idExCtrlIn));

  // R9
  single_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    idExBubble |=> !idExBubble);

  // R10
  enable_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcWriteEn == ifIdWriteEn) && (idExBubble == !pcWriteEn));

endmodule

bind lu_stall_unit lu_stall_chk #(
  .REG_W (REG_W),
  .CTRL_W(CTRL_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .exValid    (exValid),
  .exIsLoad   (exIsLoad),
  .exDestReg  (exDestReg),
  .idValid    (idValid),
  .idExCtrlIn (idExCtrlIn),
  .pcWriteEn  (pcWriteEn),
  .ifIdWriteEn(ifIdWriteEn),
  .idExBubble (idExBubble),
  .idExCtrlOut(idExCtrlOut)
);

// File: tb/test_lu_stall_unit.sv
`timescale 1ns/1ps
module test_lu_stall_unit;

  localparam int unsigned REG_W   = 5;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned CTRL_W  = 3;

  logic                     clk = 1'b0;
  logic                     rstN;
  logic                     exValid, exIsLoad, idValid;
  logic [REG_W-1:0]         exDestReg;
  logic [NUM_SRC*REG_W-1:0] idSrc;
  logic [NUM_SRC-1:0]       idUse;
  logic [CTRL_W-1:0]        idExCtrlIn;
  logic                     pcWriteEn, ifIdWriteEn, idExBubble;
  logic [CTRL_W-1:0]        idExCtrlOut;

  typedef struct {
    logic              pcEn;
    logic              ifIdEn;
    logic              bubble;
    logic [CTRL_W-1:0] ctrl;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  int  compared   = 0;
  int  mismatched = 0;
  logic modelPrev = 1'b0;
  bit   finished  = 1'b0;

  always #2 clk = !clk;  // 250 MHz

  lu_stall_unit #(
    .REG_W(REG_W), .NUM_SRC(NUM_SRC), .CTRL_W(CTRL_W)
  ) i_lu_stall_unit (
    .clk(clk), .rstN(rstN), .exValid(exValid), .exIsLoad(exIsLoad),
    .exDestReg(exDestReg), .idValid(idValid), .idSrc(idSrc), .idUse(idUse),
    .idExCtrlIn(idExCtrlIn), .pcWriteEn(pcWriteEn), .ifIdWriteEn(ifIdWriteEn),
    .idExBubble(idExBubble), .idExCtrlOut(idExCtrlOut)
  );

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic driveCycle(input logic r, input logic eV, input logic eL,
                            input logic [4:0] dest, input logic iV,
                            input logic [4:0] srcA, input logic useA,
                            input logic [4:0] srcB, input logic useB,
                            input logic [2:0] ctrl, input string tag);
    expItem_t e;
    logic hit, stall;
    @(negedge clk);
    rstN = r; exValid = eV; exIsLoad = eL; exDestReg = dest; idValid = iV;
    idSrc = {srcB, srcA}; idUse = {useB, useA}; idExCtrlIn = ctrl;
    hit   = (useA && srcA == dest) || (useB && srcB == dest);
    stall = r && eV && eL && (dest != 5'd0) && iV && hit && !modelPrev;
    modelPrev = r ? stall : 1'b0;
    e.pcEn = !stall; e.ifIdEn = !stall; e.bubble = stall;
    e.ctrl = stall ? 3'b000 : ctrl;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compares once per cycle, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        compared++;
        if (pcWriteEn !== e.pcEn || ifIdWriteEn !== e.ifIdEn ||
            idExBubble !== e.bubble || idExCtrlOut !== e.ctrl) begin
          mismatched++;
          $display("FAIL %s: got pc=%b ifid=%b bub=%b ctrl=%b, exp pc=%b ifid=%b bub=%b ctrl=%b",
                   e.tag, pcWriteEn, ifIdWriteEn, idExBubble, idExCtrlOut,
                   e.pcEn, e.ifIdEn, e.bubble, e.ctrl);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; exValid = 1'b0; exIsLoad = 1'b0; exDestReg = '0; idValid = 1'b0;
    idSrc = '0; idUse = '0; idExCtrlIn = '0;
    // R1: load-use pattern held in reset must not stall
    driveCycle(0, 1, 1, 5'd7, 1, 5'd7, 1, 5'd2, 1, 3'b111, "R1 reset");
    driveCycle(0, 1, 1, 5'd7, 1, 5'd7, 1, 5'd2, 1, 3'b101, "R1 reset");
    // R2: source A match stalls, R8 clears controls
    driveCycle(1, 1, 1, 5'd7, 1, 5'd7, 1, 5'd2, 1, 3'b111, "R2 srcA stall R8");
    // R9: same pattern next cycle, no stall
    driveCycle(1, 1, 1, 5'd7, 1, 5'd7, 1, 5'd2, 1, 3'b111, "R9 one cycle");
    driveCycle(1, 0, 0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 3'b001, "R10 idle");
    // R3: source B match stalls
    driveCycle(1, 1, 1, 5'd12, 1, 5'd3, 1, 5'd12, 1, 3'b110, "R3 srcB stall");
    // R9: new matching load right after a stall still held off
    driveCycle(1, 1, 1, 5'd9, 1, 5'd9, 1, 5'd0, 0, 3'b011, "R9 after stall");
    // R4: match with use flag off
    driveCycle(1, 1, 1, 5'd4, 1, 5'd4, 0, 5'd4, 0, 3'b101, "R4 unused src");
    // R5: destination register zero
    driveCycle(1, 1, 1, 5'd0, 1, 5'd0, 1, 5'd0, 1, 3'b111, "R5 reg zero");
    // R6: ALU op in execute
    driveCycle(1, 1, 0, 5'd6, 1, 5'd6, 1, 5'd6, 1, 3'b001, "R6 not load");
    // R7: valid bits
    driveCycle(1, 0, 1, 5'd6, 1, 5'd6, 1, 5'd1, 1, 3'b001, "R7 ex invalid");
    driveCycle(1, 1, 1, 5'd6, 0, 5'd6, 1, 5'd1, 1, 3'b001, "R7 id invalid");
    // R2: no match at all
    driveCycle(1, 1, 1, 5'd31, 1, 5'd30, 1, 5'd29, 1, 3'b010, "R2 no match");
    // R2 with max register, R8 clear
    driveCycle(1, 1, 1, 5'd31, 1, 5'd31, 1, 5'd31, 1, 3'b111, "R2 r31 stall R8");
    driveCycle(1, 1, 1, 5'd31, 1, 5'd31, 1, 5'd31, 1, 3'b111, "R9 r31 hold");
    driveCycle(1, 1, 1, 5'd31, 1, 5'd31, 1, 5'd31, 1, 3'b111, "R2 r31 restall");
    // R1: reset again mid-stream clears history
    driveCycle(0, 1, 1, 5'd5, 1, 5'd5, 1, 5'd0, 0, 3'b100, "R1 re-reset");
    driveCycle(1, 1, 1, 5'd5, 1, 5'd5, 1, 5'd0, 0, 3'b100, "R2 after reset");
    driveCycle(1, 0, 0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 3'b000, "R10 idle end");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule